// File: doc/BRIEF.md
# Configuration Load and Scrub Controller

This block takes short commands and, in response, streams configuration bytes into the byte-wide parallel configuration port of a programmable device. The bytes come from one of two places. The first is a shared flash, which the block reaches through an arbitrated flash interface. The second is a host-bus receive FIFO. The bitstream itself carries every device-level configuration command, and the block adds nothing to the data it moves. The configuration port is treated as a plain byte sink. The configuration clock pulses once for each byte that is actually ready, so bytes can arrive at any irregular rate.

Software first loads a start and a stop flash address, or a byte count for the bus. It then issues a program command. A scrub command replays the flash range at once and then again after each programmed interval, which rewrites the static configuration. This continues until scrubbing is turned off or an abort arrives. Status outputs show when a transfer is in progress and give a one-cycle pulse when it completes.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: A command is taken in any cycle where `cmd_valid` is high, and `cmd_op` selects it. The codes are: 0 no-op, 1 load start address, 2 load stop address, 3 program from flash, 4 load bus byte count, 5 program from bus, 6 scrub (`cmd_arg` is the period), 7 abort.
- R2: A flash pass first raises `fl_req`. It issues no `fl_rd` until `fl_owner` equals the parameter `OWNER_ID`.
- R3: A flash pass reads every address from start up to and including stop, with one `fl_rd` pulse per address. A byte is taken only in a cycle where `fl_valid` is high and `fl_busy` is low.
- R4: Each byte taken is placed on `cfg_data`. One cycle later `cfg_clk` is high for exactly one cycle, and `cfg_data` does not change while it is high. `cfg_clk` is low at all other times.
- R5: A bus program pops exactly the loaded count of bytes from the FIFO, in FIFO order. It never pops while `fifo_empty` is high and waits while the FIFO is empty. A count of zero finishes at once with no pop.
- R6: `st_busy` is high from the cycle after a program command is accepted until the transfer ends. `st_done` pulses for one cycle in the same cycle that `st_busy` falls.
- R7: A scrub command with a nonzero period starts a flash pass at once. After it, each further pass raises `fl_req` exactly period cycles after the previous pass's `st_done`. A scrub command with period zero stops any further passes.
- R8: One cycle after an abort is accepted, `st_busy`, `fl_req` and `cfg_clk` are low. No more bytes are delivered, and scrubbing is turned off.
- R9: While `st_busy` is high, every command except abort and scrub-off is ignored. It changes no stored address and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | ARG_W | Address, count or period argument |
| fl_req | output | 1 | Flash access request |
| fl_owner | input | OWN_W | Identity of the current flash owner |
| fl_rd | output | 1 | Flash read command pulse |
| fl_addr | output | ADDR_W | Flash read address |
| fl_data | input | 8 | Flash read data |
| fl_valid | input | 1 | Flash data valid |
| fl_busy | input | 1 | Flash interface busy |
| fifo_empty | input | 1 | Bus FIFO empty |
| fifo_data | input | 8 | Bus FIFO head byte (first-word fall-through) |
| fifo_rd | output | 1 | Bus FIFO pop |
| cfg_clk | output | 1 | Configuration clock pulse |
| cfg_data | output | 8 | Configuration byte |
| st_busy | output | 1 | Transfer in progress |
| st_done | output | 1 | One-cycle completion pulse |

## Verification
A command is driven at a falling edge and is taken at the next rising edge. `st_busy`, `fl_req` and `fl_rd` reflect the new state one edge later. Because of this, the bench checks them at the falling edge that follows the edge at which the command was taken. A byte moves onto `cfg_data` at the edge where it is taken, and `cfg_clk` rises one edge later. The bench therefore captures bytes on the rising edge of `cfg_clk` instead of counting cycles. For the scrub interval, the bench stamps both the `st_done` pulse and the next rise of `fl_req` with a cycle counter at falling edges and expects the two stamps to differ by exactly the period. The abort results are read one falling edge after the abort is taken.

// File: rtl/cfg_pkg.sv
// Shared command codes and sequencer states for the configuration controller.
package cfg_pkg;
    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_SET_START = 3'd1,
        OP_SET_STOP  = 3'd2,
        OP_FLASH     = 3'd3,
        OP_SET_COUNT = 3'd4,
        OP_BUS       = 3'd5,
        OP_SCRUB     = 3'd6,
        OP_ABORT     = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ISSUE,
        ST_WAIT,
        ST_BUS_POP,
        ST_BUS_GAP
    } seq_e;
endpackage

// File: rtl/cfg_scrub_timer.sv
// Scrub interval timer. It reloads with the period when a flash pass ends and
// counts down while scrubbing is on. It fires in the cycle the count reaches
// one, so the next pass starts exactly period cycles after the end of the
// previous one. It assumes the period is nonzero whenever run is high.
module cfg_scrub_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    output logic             fire
);
    logic [PER_W-1:0] cnt;

    // Reload on pass end, count down otherwise, clear when scrubbing is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= period;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Fire as the last count of the interval elapses.
    assign fire = run && (cnt == {{(PER_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/cfg_byte_port.sv
// Drives the byte-wide configuration port. A byte strobed in appears on the
// data lines at once, and the port clock pulses high for one cycle in the
// following cycle. It assumes strobes are at least two cycles apart. Flush
// cancels a pending pulse.
module cfg_byte_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       stb,
    input  logic [7:0] din,
    output logic       cfg_clk,
    output logic [7:0] cfg_data
);
    logic pend;

    // Latch the byte, then raise the port clock one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            cfg_clk  <= 1'b0;
            cfg_data <= '0;
        end else if (flush) begin
            pend    <= 1'b0;
            cfg_clk <= 1'b0;
        end else begin
            cfg_clk <= pend;
            pend    <= stb;
            if (stb) cfg_data <= din;
        end
    end

    assert_clk_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |=> !cfg_clk);
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> $stable(cfg_data));
endmodule

// File: rtl/cfg_stream_ctrl.sv
// Configuration load and scrub controller. It decodes commands, keeps the
// flash range and the bus count, and runs one sequencer for both sources.
// Flash: request, wait for ownership, then one read per address, taking data
// on valid and not busy. Bus: pop the first-word fall-through FIFO until the
// count is used up. It assumes the arbiter keeps the grant while fl_req stays
// high.
module cfg_stream_ctrl
    import cfg_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 16,
    parameter int PER_W    = 16,
    parameter int OWN_W    = 2,
    parameter int OWNER_ID = 1,
    localparam int ARG_W   = (ADDR_W > CNT_W) ? ((ADDR_W > PER_W) ? ADDR_W : PER_W)
                                              : ((CNT_W > PER_W) ? CNT_W : PER_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ARG_W-1:0]  cmd_arg,
    output logic              fl_req,
    input  logic [OWN_W-1:0]  fl_owner,
    output logic              fl_rd,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [7:0]        fl_data,
    input  logic              fl_valid,
    input  logic              fl_busy,
    input  logic              fifo_empty,
    input  logic [7:0]        fifo_data,
    output logic              fifo_rd,
    output logic              cfg_clk,
    output logic [7:0]        cfg_data,
    output logic              st_busy,
    output logic              st_done
);
    localparam logic [OWN_W-1:0] MY_ID = OWN_W'(OWNER_ID);

    seq_e              state;
    logic [ADDR_W-1:0] start_r, stop_r, cur;
    logic [CNT_W-1:0]  count_r, remain;
    logic [PER_W-1:0]  period_r;
    logic              scrub_on, scrub_due, fire;
    op_e               op;
    logic              abort, scrub_off, grant, fl_take, bus_take, pass_end;

    // Command decode and handshake conditions.
    always_comb begin
        op        = op_e'(cmd_op);
        abort     = cmd_valid && (op == OP_ABORT);
        scrub_off = cmd_valid && (op == OP_SCRUB) && (cmd_arg[PER_W-1:0] == '0);
        grant     = (fl_owner == MY_ID);
        fl_take   = (state == ST_WAIT) && fl_valid && !fl_busy;
        bus_take  = (state == ST_BUS_POP) && !fifo_empty && !abort;
        pass_end  = fl_take && (cur == stop_r);
    end

    assign fl_req  = (state == ST_REQ) || (state == ST_ISSUE) || (state == ST_WAIT);
    assign fl_rd   = (state == ST_ISSUE);
    assign fl_addr = cur;
    assign fifo_rd = bus_take;
    assign st_busy = (state != ST_IDLE);

    // Sequencer: command intake in idle, then the flash or bus transfer loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            start_r   <= '0;
            stop_r    <= '0;
            count_r   <= '0;
            remain    <= '0;
            cur       <= '0;
            period_r  <= '0;
            scrub_on  <= 1'b0;
            scrub_due <= 1'b0;
            st_done   <= 1'b0;
        end else if (abort) begin
            state     <= ST_IDLE;
            scrub_on  <= 1'b0;
            scrub_due <= 1'b0;
            st_done   <= 1'b0;
        end else begin
            st_done <= 1'b0;
            if (fire) scrub_due <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        case (op)
                            OP_SET_START: start_r <= cmd_arg[ADDR_W-1:0];
                            OP_SET_STOP:  stop_r  <= cmd_arg[ADDR_W-1:0];
                            OP_SET_COUNT: count_r <= cmd_arg[CNT_W-1:0];
                            OP_FLASH: begin
                                cur   <= start_r;
                                state <= ST_REQ;
                            end
                            OP_BUS: begin
                                if (count_r == '0) begin
                                    st_done <= 1'b1;
                                end else begin
                                    remain <= count_r;
                                    state  <= ST_BUS_POP;
                                end
                            end
                            OP_SCRUB: begin
                                if (cmd_arg[PER_W-1:0] != '0) begin
                                    scrub_on  <= 1'b1;
                                    period_r  <= cmd_arg[PER_W-1:0];
                                    scrub_due <= 1'b0;
                                    cur       <= start_r;
                                    state     <= ST_REQ;
                                end
                            end
                            default: ;
                        endcase
                    end else if (scrub_on && (fire || scrub_due)) begin
                        scrub_due <= 1'b0;
                        cur       <= start_r;
                        state     <= ST_REQ;
                    end
                end
                ST_REQ:   if (grant) state <= ST_ISSUE;
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (pass_end) begin
                        state   <= ST_IDLE;
                        st_done <= 1'b1;
                    end else if (fl_take) begin
                        cur   <= cur + 1'b1;
                        state <= ST_ISSUE;
                    end
                end
                ST_BUS_POP: begin
                    if (bus_take) begin
                        remain <= remain - 1'b1;
                        if (remain == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                            state   <= ST_IDLE;
                            st_done <= 1'b1;
                        end else begin
                            state <= ST_BUS_GAP;
                        end
                    end
                end
                ST_BUS_GAP: state <= ST_BUS_POP;
                default:    state <= ST_IDLE;
            endcase
            if (scrub_off) begin
                scrub_on  <= 1'b0;
                scrub_due <= 1'b0;
            end
        end
    end

    cfg_scrub_timer #(.PER_W(PER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (scrub_on),
        .restart (pass_end),
        .period  (period_r),
        .fire    (fire)
    );

    cfg_byte_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (abort),
        .stb      (fl_take || bus_take),
        .din      (fl_take ? fl_data : fifo_data),
        .cfg_clk  (cfg_clk),
        .cfg_data (cfg_data)
    );

    assert_rd_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd |-> (fl_owner == MY_ID));
    assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);
    assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> !st_busy);
    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd7) |=> (!st_busy && !fl_req && !cfg_clk));
endmodule

// File: tb/sim_cfg_stream_ctrl.sv
`timescale 1ns/100ps
module sim_cfg_stream_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_arg = '0;
    logic        fl_req, fl_rd, fifo_rd, cfg_clk, st_busy, st_done;
    logic [1:0]  fl_owner = '0;
    logic [15:0] fl_addr;
    logic [7:0]  fl_data = '0, cfg_data;
    logic        fl_valid = 1'b0, fl_busy = 1'b0;
    logic [7:0]  fifo_mem [0:31];
    int          wp = 0, rp = 0;
    logic        fifo_empty;
    logic [7:0]  fifo_data;

    int total = 0, bad = 0, cyc = 0;
    logic [7:0] cap [0:255];
    int ncap = 0, rd_cnt = 0, bad_grant = 0, pop_cnt = 0, wide_cfg = 0;
    int done_cnt = 0, rises = 0, t_done = 0, t_req = 0;
    logic prev_cfg = 1'b0, prev_req = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cfg_stream_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .fl_req(fl_req), .fl_owner(fl_owner), .fl_rd(fl_rd),
        .fl_addr(fl_addr), .fl_data(fl_data), .fl_valid(fl_valid),
        .fl_busy(fl_busy), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
        .st_busy(st_busy), .st_done(st_done)
    );

    // Bus FIFO model, first-word fall-through.
    assign fifo_empty = (wp == rp);
    assign fifo_data  = fifo_mem[rp[4:0]];
    always @(posedge clk) if (fifo_rd) rp <= rp + 1;

    // Arbiter model: grant follows the request two cycles later.
    logic g1 = 1'b0;
    always @(posedge clk) begin
        g1       <= fl_req;
        fl_owner <= g1 ? 2'd1 : 2'd0;
    end

    // Flash model: data = addr ^ 0x5A two cycles after a read, optional busy stall.
    logic        pend = 1'b0, stall_once = 1'b0;
    logic [15:0] paddr = '0;
    int          lat = 0;
    always @(posedge clk) begin
        fl_valid <= 1'b0;
        fl_busy  <= 1'b0;
        if (fl_rd) begin
            pend  <= 1'b1;
            paddr <= fl_addr;
            lat   <= 1;
        end else if (pend) begin
            if (lat != 0) lat <= lat - 1;
            else if (stall_once) begin
                fl_valid   <= 1'b1;
                fl_busy    <= 1'b1;
                fl_data    <= 8'hFF;
                stall_once <= 1'b0;
            end else begin
                fl_valid <= 1'b1;
                fl_data  <= paddr[7:0] ^ 8'h5A;
                pend     <= 1'b0;
            end
        end
    end

    // Capture configuration bytes at the port clock.
    always @(posedge cfg_clk) begin
        if (ncap < 256) cap[ncap] = cfg_data;
        ncap = ncap + 1;
    end

    // Monitors sampled away from the active edge.
    always @(negedge clk) begin
        if (fl_rd) begin
            rd_cnt = rd_cnt + 1;
            if (fl_owner != 2'd1) bad_grant = bad_grant + 1;
        end
        if (fifo_rd) pop_cnt = pop_cnt + 1;
        if (cfg_clk && prev_cfg) wide_cfg = wide_cfg + 1;
        if (st_done) begin done_cnt = done_cnt + 1; t_done = cyc; end
        if (fl_req && !prev_req) begin rises = rises + 1; t_req = cyc; end
        prev_cfg = cfg_clk;
        prev_req = fl_req;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [15:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = '0;
    endtask

    task automatic wait_done(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            if (st_done) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic push(input logic [7:0] v);
        @(negedge clk);
        fifo_mem[wp[4:0]] = v;
        wp = wp + 1;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic t_reset;
        chk(!st_busy && !st_done, "R6 reset status", int'(st_busy), 0);
        chk(!fl_req && !fl_rd, "R2 reset flash idle", int'(fl_req), 0);
        chk(!cfg_clk && !fifo_rd, "R4 reset port quiet", int'(cfg_clk), 0);
    endtask

    task automatic t_flash(input int s, input int e, input bit stall, input string tag);
        int c0, r0, d0; bit seen;
        c0 = ncap; r0 = rd_cnt; d0 = done_cnt;
        send(3'd1, 16'(s));
        send(3'd2, 16'(e));
        stall_once = stall;
        send(3'd3, 16'd0);
        chk(st_busy && fl_req, {"R6 busy after program ", tag}, int'(st_busy), 1);
        wait_done(400, seen);
        chk(seen, {"R6 done seen ", tag}, int'(seen), 1);
        @(negedge clk);
        chk(!st_busy, {"R6 done ends busy ", tag}, int'(st_busy), 0);
        repeat (3) @(negedge clk);
        chk(ncap - c0 == e - s + 1, {"R3 byte count ", tag}, ncap - c0, e - s + 1);
        chk(rd_cnt - r0 == e - s + 1, {"R3 read count ", tag}, rd_cnt - r0, e - s + 1);
        chk(done_cnt - d0 == 1, {"R6 one done pulse ", tag}, done_cnt - d0, 1);
        for (int k = 0; k <= e - s; k++)
            chk(cap[c0+k] == (8'(s + k) ^ 8'h5A), {"R3 byte value ", tag},
                int'(cap[c0+k]), int'(8'(s + k) ^ 8'h5A));
    endtask

    task automatic t_bus;
        int c0, p0; bit seen;
        for (int k = 0; k < 8; k++) push(8'(8'hA0 + k));
        c0 = ncap; p0 = pop_cnt;
        send(3'd4, 16'd5);
        send(3'd5, 16'd0);
        wait_done(200, seen);
        chk(seen, "R5 bus done", int'(seen), 1);
        repeat (3) @(negedge clk);
        chk(pop_cnt - p0 == 5, "R5 exact pop count", pop_cnt - p0, 5);
        chk(wp - rp == 3, "R5 FIFO remainder", wp - rp, 3);
        for (int k = 0; k < 5; k++)
            chk(cap[c0+k] == 8'(8'hA0 + k), "R5 FIFO order", int'(cap[c0+k]), 8'hA0 + k);
        rp = wp;
    endtask

    task automatic t_bus_zero;
        int p0, d0;
        p0 = pop_cnt; d0 = done_cnt;
        push(8'h11);
        send(3'd4, 16'd0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd5;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        chk(st_done && !st_busy, "R5 zero count done at once", int'(st_done), 1);
        repeat (4) @(negedge clk);
        chk(pop_cnt == p0, "R5 zero count no pop", pop_cnt - p0, 0);
        chk(done_cnt - d0 == 1, "R6 zero count single pulse", done_cnt - d0, 1);
        rp = wp;
    endtask

    task automatic t_bus_stall;
        int c0; bit seen;
        c0 = ncap;
        send(3'd4, 16'd3);
        send(3'd5, 16'd0);
        repeat (10) @(negedge clk);
        chk(st_busy && ncap == c0, "R5 waits on empty FIFO", ncap - c0, 0);
        push(8'h31); push(8'h32); push(8'h33);
        wait_done(100, seen);
        repeat (3) @(negedge clk);
        chk(seen && ncap - c0 == 3, "R5 resumes after fill", ncap - c0, 3);
        chk(cap[c0+2] == 8'h33, "R5 last stalled byte", int'(cap[c0+2]), 8'h33);
    endtask

    task automatic t_ignore;
        int c0, p0; bit seen;
        push(8'h77); push(8'h78);
        send(3'd4, 16'd2);
        send(3'd1, 16'd20);
        send(3'd2, 16'd27);
        c0 = ncap; p0 = pop_cnt;
        send(3'd3, 16'd0);
        send(3'd5, 16'd0);
        send(3'd1, 16'd0);
        wait_done(400, seen);
        repeat (3) @(negedge clk);
        chk(pop_cnt == p0, "R9 bus program ignored while busy", pop_cnt - p0, 0);
        chk(ncap - c0 == 8, "R9 flash pass unchanged", ncap - c0, 8);
        c0 = ncap;
        send(3'd3, 16'd0);
        wait_done(400, seen);
        repeat (3) @(negedge clk);
        chk(cap[c0] == (8'd20 ^ 8'h5A), "R9 start address kept", int'(cap[c0]), int'(8'd20 ^ 8'h5A));
        rp = wp;
    endtask

    task automatic t_scrub;
        int r0; bit seen;
        send(3'd1, 16'd3);
        send(3'd2, 16'd4);
        send(3'd6, 16'd20);
        chk(fl_req, "R7 scrub starts at once", int'(fl_req), 1);
        wait_done(200, seen);
        r0 = rises;
        @(negedge clk);
        for (int i = 0; i < 100 && rises == r0; i++) @(negedge clk);
        chk(t_req - t_done == 20, "R7 scrub interval", t_req - t_done, 20);
        wait_done(200, seen);
        chk(seen, "R7 second pass done", int'(seen), 1);
        send(3'd6, 16'd0);
        r0 = rises;
        repeat (60) @(negedge clk);
        chk(rises == r0 && !st_busy, "R7 scrub off stops passes", rises - r0, 0);
    endtask

    task automatic t_abort;
        int c0;
        send(3'd1, 16'd0);
        send(3'd2, 16'd40);
        send(3'd6, 16'd9);
        for (int i = 0; i < 200 && ncap < 3 + 0; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        send(3'd7, 16'd0);
        chk(!st_busy && !fl_req && !cfg_clk, "R8 abort quiets outputs",
            int'({st_busy, fl_req, cfg_clk}), 0);
        c0 = ncap;
        repeat (40) @(negedge clk);
        chk(ncap == c0, "R8 no bytes after abort", ncap - c0, 0);
        chk(!fl_req, "R8 scrub off after abort", int'(fl_req), 0);
    endtask

    initial begin
        #(5.0 * 100000);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flash(10, 15, 1'b0, "R1 plain");
        chk(bad_grant == 0, "R2 no read before grant", bad_grant, 0);
        t_flash(5, 6, 1'b1, "busy stall");
        chk(wide_cfg == 0, "R4 single cycle port clock", wide_cfg, 0);
        t_bus();
        t_bus_zero();
        t_bus_stall();
        t_ignore();
        t_scrub();
        t_abort();
        chk(wide_cfg == 0 && bad_grant == 0, "R4 R2 final monitors", wide_cfg + bad_grant, 0);
        summary();
    end
endmodule